// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from six external pins, ranks them by a per-source programmable level, and hands the processor a single registered request together with the number of the source that won. Each external pin can be set to level or edge detection. A global threshold hides every source whose level does not exceed it, so software can raise the floor while it services a higher-level event.

A 16-bit software flag register serves as one more interrupt source toward the processor. Whenever any bit of it is set, it also drives a request line toward external devices. A separate active-low non-maskable input is synchronized and turned into a one-cycle pulse on its falling edge. This pulse does not pass through the priority or threshold logic. Software reaches every setting through a plain single-cycle register port with a combinational read path.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req_o, irq_id_o, flag_irq_o and nmi_o are 0, and every priority level, the edge-mode bits, the pending bits, the threshold and the flag register all read 0.
- R2: Source numbers are fixed. External pin k is source k (0..5), internal input j is source 6+j (6..13), and the flag register is source 14. The 3-bit level of source n is at address n in bits [2:0]. A level of 0 disables the source.
- R3: Among the active sources that qualify, the one with the highest level wins. When levels are equal, the lower source number wins.
- R4: The threshold register at address 0x22, bits [2:0], lets through only the sources whose level is strictly greater than it. With a threshold of 7, no request is raised.
- R5: An external pin whose edge-mode bit is 0 is level-sensitive and active high. It follows the pin through a two-stage synchronizer, and irq_req_o responds on the third rising clock edge after the pin changes.
- R6: An external pin whose edge-mode bit is 1 (address 0x20, bit k for pin k) sets pending bit k (address 0x22 is not involved; pending is at 0x21, bit k) on a synchronized rising edge. The bit stays set after the pin falls. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A pin in level mode never sets its pending bit.
- R7: The flag register at address 0x23 holds 16 bits that can be read and written. flag_irq_o is 1 exactly when any of its bits is 1. A nonzero flag register also makes source 14 active.
- R8: A falling edge on nmi_ni gives exactly one cycle of nmi_o, two to three clocks later. This happens whatever the levels and the threshold are, and irq_req_o does not change.
- R9: irq_req_o and irq_id_o are registered and are recomputed every clock from the state of the previous cycle. irq_id_o is 0 whenever irq_req_o is 0.
- R10: Every register reads back what was written, limited to its width: levels are 3 bits, edge mode is 6 bits and the threshold is 3 bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 6 | External interrupt pins, asynchronous, active high |
| int_irq_i | input | 8 | Internal peripheral requests, synchronous, active high |
| nmi_ni | input | 1 | Non-maskable input, asynchronous, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| irq_req_o | output | 1 | Prioritized request to the processor |
| irq_id_o | output | 4 | Number of the winning source |
| flag_irq_o | output | 1 | Outward request, any flag bit set |
| nmi_o | output | 1 | One-cycle non-maskable pulse |

## Verification
A corrupted level or threshold register appears on irq_id_o or irq_req_o on the clock after the affected source becomes active. The sweeps over every level and threshold pair, and over all 256 patterns of internal sources, therefore expose it within one cycle of the stimulus. A pending bit that is stuck or cleared wrongly appears both on the read port and as a request that stays or is missing once the pin has settled. A broken edge detector on the non-maskable path shows up as a missing pulse, or as more than one pulse within a few clocks of the falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // register port address width and fixed register addresses
    localparam int          IRQ_ADDR_W = 6;
    localparam logic [5:0]  A_EDGE     = 6'h20;  // per-pin edge/level select
    localparam logic [5:0]  A_PEND     = 6'h21;  // edge pending, write 1 to clear
    localparam logic [5:0]  A_MASK     = 6'h22;  // global threshold level
    localparam logic [5:0]  A_FLAG     = 6'h23;  // software flag register

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q.chain <= {STAGES{RST_VAL}};
        else         sync_q       <= sync_d;
    end

    assign lvl_o = sync_q.chain[STAGES-1];

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NSRC   = 15,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [NSRC-1:0]             act_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]           mask_i,
    output logic                        hit_o,
    output logic [ID_W-1:0]             id_o
);

    logic [PRIO_W-1:0] best_lvl;
    logic [ID_W-1:0]   best_id;

    // ascending scan with strict compare: equal levels keep the lower index
    always_comb begin
        best_lvl = '0;
        best_id  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (act_i[i] && (prio_i[i] > mask_i) && (prio_i[i] > best_lvl)) begin
                best_lvl = prio_i[i];
                best_id  = ID_W'(i);
            end
        end
    end

    assign hit_o = (best_lvl != '0);
    assign id_o  = best_id;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter  int NUM_EXT     = 6,
    parameter  int NUM_INT     = 8,
    parameter  int PRIO_W      = 3,
    parameter  int FLAG_W      = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int NSRC        = NUM_EXT + NUM_INT + 1,
    localparam int ID_W        = $clog2(NSRC)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_EXT-1:0]    ext_irq_i,
    input  logic [NUM_INT-1:0]    int_irq_i,
    input  logic                  nmi_ni,
    input  logic                  reg_wr_i,
    input  logic [IRQ_ADDR_W-1:0] reg_addr_i,
    input  logic [FLAG_W-1:0]     reg_wdata_i,
    output logic [FLAG_W-1:0]     reg_rdata_o,
    output logic                  irq_req_o,
    output logic [ID_W-1:0]       irq_id_o,
    output logic                  flag_irq_o,
    output logic                  nmi_o
);

    localparam int FLAG_SRC = NSRC - 1;

    typedef struct packed {
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_EXT-1:0]          edge_mode;
        logic [NUM_EXT-1:0]          pend;
        logic [NUM_EXT-1:0]          ext_prev;
        logic [PRIO_W-1:0]           mask;
        logic [FLAG_W-1:0]           flag;
        logic                        nmi_prev;
        logic                        nmi;
        logic                        req;
        logic [ID_W-1:0]             id;
    } ctrl_t;

    ctrl_t state_d, state_q;

    logic [NUM_EXT-1:0] ext_lvl;
    logic [NUM_EXT-1:0] ext_rise;
    logic [NUM_EXT-1:0] ext_act;
    logic               nmi_lvl;
    logic [NSRC-1:0]    src_act;
    logic               arb_hit;
    logic [ID_W-1:0]    arb_id;

    // synchronizers for the asynchronous pins
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (ext_irq_i[e]),
            .lvl_o  (ext_lvl[e])
        );
    end

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (nmi_ni),
        .lvl_o  (nmi_lvl)
    );

    // source activity: edge pins use their pending bit, level pins the pin
    assign ext_rise = ext_lvl & ~state_q.ext_prev;
    assign ext_act  = (state_q.edge_mode & state_q.pend) | (~state_q.edge_mode & ext_lvl);
    assign src_act  = {(|state_q.flag), int_irq_i, ext_act};

    irq_prio_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .act_i  (src_act),
        .prio_i (state_q.prio),
        .mask_i (state_q.mask),
        .hit_o  (arb_hit),
        .id_o   (arb_id)
    );

    always_comb begin
        state_d          = state_q;
        state_d.ext_prev = ext_lvl;
        state_d.nmi_prev = nmi_lvl;
        state_d.nmi      = state_q.nmi_prev & ~nmi_lvl;

        if (reg_wr_i) begin
            for (int i = 0; i < NSRC; i++) begin
                if (reg_addr_i == IRQ_ADDR_W'(i)) begin
                    state_d.prio[i] = reg_wdata_i[PRIO_W-1:0];
                end
            end
            case (reg_addr_i)
                A_EDGE:  state_d.edge_mode = reg_wdata_i[NUM_EXT-1:0];
                A_PEND:  state_d.pend      = state_q.pend & ~reg_wdata_i[NUM_EXT-1:0];
                A_MASK:  state_d.mask      = reg_wdata_i[PRIO_W-1:0];
                A_FLAG:  state_d.flag      = reg_wdata_i;
                default: ;
            endcase
        end

        // a new edge in the same cycle as a clear wins
        state_d.pend = state_d.pend | (ext_rise & state_q.edge_mode);

        state_d.req = arb_hit;
        state_d.id  = arb_hit ? arb_id : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q          <= '0;
            state_q.nmi_prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    // combinational read path
    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (reg_addr_i == IRQ_ADDR_W'(i)) begin
                reg_rdata_o = FLAG_W'(state_q.prio[i]);
            end
        end
        case (reg_addr_i)
            A_EDGE:  reg_rdata_o = FLAG_W'(state_q.edge_mode);
            A_PEND:  reg_rdata_o = FLAG_W'(state_q.pend);
            A_MASK:  reg_rdata_o = FLAG_W'(state_q.mask);
            A_FLAG:  reg_rdata_o = state_q.flag;
            default: ;
        endcase
    end

    assign irq_req_o  = state_q.req;
    assign irq_id_o   = state_q.id;
    assign flag_irq_o = |state_q.flag;
    assign nmi_o      = state_q.nmi;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NSRC   = 15,
    parameter int ID_W   = 4,
    parameter int PRIO_W = 3,
    parameter int FLAG_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic [5:0]        reg_addr_i,
    input logic [FLAG_W-1:0] reg_wdata_i,
    input logic              irq_req_o,
    input logic [ID_W-1:0]   irq_id_o,
    input logic              flag_irq_o,
    input logic              nmi_o,
    input logic [PRIO_W-1:0] mask_q
);

    // R1: first cycle out of reset carries no request
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!irq_req_o && !nmi_o));

    // R9: no request means source number 0
    p_idle_id_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_req_o |-> (irq_id_o == '0));

    // R2: a granted source number always names a real source
    p_id_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> (int'(irq_id_o) < NSRC));

    // R4: full threshold blocks every source on the next cycle
    p_mask_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '1) |=> !irq_req_o);

    // R8: the non-maskable pulse lasts one cycle
    p_nmi_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |=> !nmi_o);

    // R7: outward line tracks writes of the flag register
    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 6'h23 && reg_wdata_i != '0) |=> flag_irq_o);

    p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 6'h23 && reg_wdata_i == '0) |=> !flag_irq_o);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NSRC   (NSRC),
    .ID_W   (ID_W),
    .PRIO_W (PRIO_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_req_o   (irq_req_o),
    .irq_id_o    (irq_id_o),
    .flag_irq_o  (flag_irq_o),
    .nmi_o       (nmi_o),
    .mask_q      (state_q.mask)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_irq = '0;
    logic [7:0]  int_irq = '0;
    logic        nmi_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic [3:0]  irq_id;
    logic        flag_irq;
    logic        nmi_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ext_irq_i   (ext_irq),
        .int_irq_i   (int_irq),
        .nmi_ni      (nmi_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_req_o   (irq_req),
        .irq_id_o    (irq_id),
        .flag_irq_o  (flag_irq),
        .nmi_o       (nmi_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 6'(a);
        reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        reg_addr = 6'(a);
        #1;
        chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    endtask

    // encodes request and id together: 0 when idle, 16+id when requesting
    task automatic out(input bit req, input int id, input string tag);
        int a;
        int e;
        a = irq_req ? 16 + int'(irq_id) : int'(irq_id);
        e = req ? 16 + id : 0;
        chk(a == e, tag, a, e);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pr[8];
        int cnt;
        // ---- R1 reset state
        settle(3);
        out(1'b0, 0, "R1 outputs in reset");
        chk(flag_irq == 1'b0 && nmi_pulse == 1'b0, "R1 flag/nmi in reset", int'(flag_irq), 0);
        rst_n = 1'b1;
        settle(2);
        for (int i = 0; i < 15; i++) rd(i, 0, "R1 level reset");
        rd(32, 0, "R1 edge reset");
        rd(33, 0, "R1 pend reset");
        rd(34, 0, "R1 mask reset");
        rd(35, 0, "R1 flag reset");

        // ---- R10 readback with width limits
        for (int i = 0; i < 15; i++) wr(i, 8 + (i % 7) + 1);
        for (int i = 0; i < 15; i++) rd(i, (i % 7) + 1, "R10 level readback");
        for (int i = 0; i < 15; i++) wr(i, 0);
        wr(32, 16'hFFFF); rd(32, 16'h003F, "R10 edge width");
        wr(32, 0);
        wr(34, 16'h000D); rd(34, 5, "R10 mask width");
        wr(34, 0);
        wr(35, 16'hA5A5); rd(35, 16'hA5A5, "R10 flag readback");
        wr(35, 0);
        rd(40, 0, "R10 unmapped");
        rd(63, 0, "R10 unmapped top");

        // ---- R9 registered timing, id 0 when idle
        wr(6, 3);
        @(negedge clk);
        int_irq = 8'h01;
        #1;
        out(1'b0, 0, "R9 before edge");
        @(negedge clk);
        out(1'b1, 6, "R9 one clock later");
        int_irq = 8'h00;
        @(negedge clk);
        out(1'b0, 0, "R9 drop one clock later");
        wr(6, 0);

        // ---- R4 / R2 level-vs-threshold sweep on source 7
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 8; m++) begin
                wr(7, p);
                wr(34, m);
                int_irq = 8'h02;
                settle(2);
                out(p > m, 7, "R4 level vs threshold");
                int_irq = 8'h00;
            end
        end
        wr(34, 0);
        wr(7, 0);
        settle(2);

        // ---- R3 exhaustive pattern sweep, distinct then equal levels
        for (int mode = 0; mode < 2; mode++) begin
            for (int i = 0; i < 8; i++) begin
                pr[i] = (mode == 0) ? (i * 5 + 3) % 8 : 4;
                wr(6 + i, pr[i]);
            end
            wr(34, 1);
            for (int pat = 0; pat < 256; pat++) begin
                int best;
                int bid;
                best = 0;
                bid  = 0;
                for (int i = 0; i < 8; i++) begin
                    if (pat[i] && pr[i] > 1 && pr[i] > best) begin
                        best = pr[i];
                        bid  = 6 + i;
                    end
                end
                int_irq = 8'(pat);
                settle(2);
                out(best != 0, bid, mode == 0 ? "R3 highest level wins" : "R3 tie lower id");
            end
            int_irq = 8'h00;
        end
        for (int i = 0; i < 8; i++) wr(6 + i, 0);
        wr(34, 0);
        settle(2);

        // ---- R5 level-mode external pins
        wr(0, 4);
        @(negedge clk);
        ext_irq = 6'h01;
        settle(2);
        out(1'b0, 0, "R5 not yet after two edges");
        settle(1);
        out(1'b1, 0, "R5 on third edge");
        ext_irq = 6'h00;
        settle(4);
        out(1'b0, 0, "R5 follows pin low");
        wr(0, 0);
        for (int k = 0; k < 6; k++) begin
            wr(k, 4);
            ext_irq = 6'(1 << k);
            settle(4);
            out(1'b1, k, "R5 pin numbering");
            ext_irq = 6'h00;
            settle(4);
            out(1'b0, 0, "R5 pin released");
            wr(k, 0);
        end
        // tie between external pin 5 and internal source 6
        wr(5, 4); wr(6, 4);
        ext_irq = 6'h20; int_irq = 8'h01;
        settle(4);
        out(1'b1, 5, "R3 external beats internal on tie");
        ext_irq = 6'h00; int_irq = 8'h00;
        wr(5, 0); wr(6, 0);
        settle(4);

        // ---- R6 edge mode
        wr(32, 16'h0004);
        wr(2, 5);
        @(negedge clk);
        ext_irq = 6'h04;
        @(negedge clk);
        ext_irq = 6'h00;
        settle(5);
        out(1'b1, 2, "R6 edge latched");
        rd(33, 4, "R6 pending set");
        wr(33, 16'h003B);
        settle(2);
        out(1'b1, 2, "R6 write 0 keeps pending");
        rd(33, 4, "R6 pending kept");
        wr(33, 16'h0004);
        settle(2);
        out(1'b0, 0, "R6 cleared by write 1");
        rd(33, 0, "R6 pending cleared");
        wr(32, 0);
        wr(3, 5);
        @(negedge clk);
        ext_irq = 6'h08;
        @(negedge clk);
        ext_irq = 6'h00;
        settle(5);
        out(1'b0, 0, "R6 level pin pulse gone");
        rd(33, 0, "R6 level pin no pending");
        wr(3, 0);
        wr(2, 0);

        // ---- R7 flag register
        wr(14, 6);
        wr(35, 16'h8000);
        chk(flag_irq == 1'b1, "R7 flag out set", int'(flag_irq), 1);
        settle(1);
        out(1'b1, 14, "R7 flag source");
        wr(35, 0);
        chk(flag_irq == 1'b0, "R7 flag out clear", int'(flag_irq), 0);
        settle(1);
        out(1'b0, 0, "R7 flag source gone");
        wr(14, 0);
        for (int b = 0; b < 16; b++) begin
            wr(35, 1 << b);
            chk(flag_irq == 1'b1, "R7 single bit outward", int'(flag_irq), 1);
            rd(35, 1 << b, "R7 flag bit readback");
            settle(1);
            out(1'b0, 0, "R7 level 0 keeps processor quiet");
        end
        wr(35, 0);

        // ---- R8 non-maskable path
        wr(34, 7);
        @(negedge clk);
        nmi_n = 1'b0;
        cnt = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (nmi_pulse) cnt++;
            if (irq_req) cnt += 100;
        end
        chk(cnt == 1, "R8 one pulse on fall", cnt, 1);
        nmi_n = 1'b1;
        cnt = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (nmi_pulse) cnt++;
        end
        chk(cnt == 0, "R8 no pulse on rise", cnt, 0);
        wr(34, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule